// File: doc/BRIEF.md
# 64-bit Snapshot Timer with Compare Channels

This block is a free-running 64-bit up-counter that software reaches through a plain 32-bit register port. A prescaler turns the input clock into count ticks at a programmable fraction of its rate. The live count is visible and can be preset, but a consistent 64-bit value is read by first writing a capture command. That command copies both halves into shadow registers at the same clock edge, so the two halves are then read one after the other without tearing.

Six 32-bit compare channels watch the low word of the count. When a tick moves the count onto a channel's compare value, that channel's sticky status bit is set. Software clears the bit by writing a one to it. Each status bit can be enabled onto a shared interrupt line. The last channel can also act as a watchdog: while its arm bit is set, its compare event emits a one-cycle reset request.

Top module: `match_timer64`

## Requirements
- R1: With divider value D (word 11, byte 0x2C), the count advances by exactly one per 2×(D+1) input clocks, and the low word carries into the high word. The low word is at word 0 and the high word is at word 1.
- R2: Writing a value with bit 0 set to word 12 copies the whole 64-bit count, as it stood before that edge, into the snapshot low (word 13) and snapshot high (word 14) registers. A write to word 12 with bit 0 clear changes nothing.
- R3: Writes to word 0 or word 1 replace that half of the count. When such a write meets a tick in the same cycle, the write takes effect and the tick is dropped.
- R4: Channel n (compare register at word 2+n) sets status bit n in the cycle after a tick brings the low word equal to its compare value. A software write that lands on the compare value sets nothing. A later wrap onto the value sets the bit again.
- R5: Writing word 8 clears each status bit whose data bit is 1 and leaves the others unchanged. A compare event in the same cycle wins over the clear.
- R6: irq_o is high exactly when some status bit n and its enable bit n (word 9) are both 1.
- R7: While bit 0 of word 10 is 1, a compare event on channel 5 also gives a single-cycle wdog_rst_o pulse, aligned with its status bit being set. While that bit is 0, no pulse occurs and the status bit is still set.
- R8: Reads of words 12 and 15, and of any byte offset whose two low bits are not zero, return 0. Writes to such offsets change nothing.
- R9: After reset the count, status, enables, watchdog arm bit, divider and snapshot registers are zero, and every compare register is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe for the addressed register |
| bus_addr_i | input | ADDR_W (6) | Byte offset of the register |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Combined interrupt from the enabled status bits |
| wdog_rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
The hardest cases to reach are those where a tick falls in the same edge as something else: a counter write (the tick must be dropped), a status clear (the compare event must survive), or a capture command (the snapshot must hold the value from before the tick). Divider values stay between 0 and 3, so ticks come every two to eight clocks. The low word is often moved to just below a compare value or just below the wrap point. Writes then land on random phases of the prescaler, and a behavioural model checks every output on every clock to catch these collisions.

// File: rtl/mt_pkg.sv
package mt_pkg;

   // Word index (byte offset / 4) of each register
   typedef enum logic [3:0] {
      REG_CNT_LO  = 4'd0,
      REG_CNT_HI  = 4'd1,
      REG_CMP0    = 4'd2,
      REG_STATUS  = 4'd8,
      REG_IRQ_EN  = 4'd9,
      REG_WDOG_EN = 4'd10,
      REG_DIV     = 4'd11,
      REG_SNAP    = 4'd12,
      REG_SNAP_LO = 4'd13,
      REG_SNAP_HI = 4'd14
   } reg_idx_e;

   localparam int unsigned IDX_W  = 4;
   localparam int unsigned MAX_CH = 6;

endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
   parameter int unsigned DIV_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);
   localparam int unsigned PC_W = DIV_W + 1;

   logic [PC_W-1:0] pcnt_q;
   logic [PC_W-1:0] last_val;

   // period of 2*(div+1) clocks: count 0 .. 2*div+1
   assign last_val = {div_i, 1'b1};
   // ">=" also recovers at once when the divider shrinks below the count
   assign tick_o   = (pcnt_q >= last_val);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pcnt_q <= '0;
      end else if (tick_o) begin
         pcnt_q <= '0;
      end else begin
         pcnt_q <= pcnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 64
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              wr_lo_i,
   input  logic              wr_hi_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              step_o
);
   localparam int unsigned HI_W = CNT_W - DATA_W;

   logic [CNT_W-1:0] cnt_q;
   logic             step_q;
   logic             any_wr;

   assign any_wr = wr_lo_i | wr_hi_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (any_wr) begin
         // software write wins; the tick of this cycle is dropped
         if (wr_lo_i) cnt_q[DATA_W-1:0]     <= wdata_i;
         if (wr_hi_i) cnt_q[CNT_W-1:DATA_W] <= wdata_i[HI_W-1:0];
      end else if (tick_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // marks a count value that was reached by a tick
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) step_q <= 1'b0;
      else         step_q <= tick_i & ~any_wr;
   end

   assign cnt_o  = cnt_q;
   assign step_o = step_q;

endmodule

// File: rtl/mt_cmp_bank.sv
module mt_cmp_bank #(
   parameter int unsigned NUM_CH = 6,
   parameter int unsigned DATA_W = 32
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic [DATA_W-1:0]              cnt_lo_i,
   input  logic                           step_i,
   input  logic [NUM_CH-1:0]              cmp_we_i,
   input  logic [DATA_W-1:0]              wdata_i,
   input  logic                           clr_we_i,
   input  logic [NUM_CH-1:0]              clr_mask_i,
   output logic [NUM_CH-1:0][DATA_W-1:0]  cmp_o,
   output logic [NUM_CH-1:0]              status_o,
   output logic                           last_hit_o
);
   logic [NUM_CH-1:0] hit;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [DATA_W-1:0] cmp_q;
      logic              flag_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)           cmp_q <= '1;
         else if (cmp_we_i[ch]) cmp_q <= wdata_i;
      end

      // only a count reached by a tick can fire
      assign hit[ch] = step_i && (cnt_lo_i == cmp_q);

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                           flag_q <= 1'b0;
         else if (hit[ch])                      flag_q <= 1'b1;
         else if (clr_we_i && clr_mask_i[ch])   flag_q <= 1'b0;
      end

      assign cmp_o[ch]    = cmp_q;
      assign status_o[ch] = flag_q;
   end

   assign last_hit_o = hit[NUM_CH-1];

endmodule

// File: rtl/match_timer64.sv
module match_timer64
   import mt_pkg::*;
#(
   parameter int unsigned NUM_CH   = 6,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CNT_W    = 64,
   parameter int unsigned DIV_W    = 32,
   parameter int unsigned ADDR_W   = 6,
   parameter bit          HAS_WDOG = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o,
   output logic              wdog_rst_o
);
   localparam int unsigned WDOG_CH = NUM_CH - 1;
   localparam int unsigned HI_W    = CNT_W - DATA_W;

   // elaboration-time parameter checks
   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_ch
      $error("NUM_CH must lie in 1..6");
   end
   if (CNT_W != 2 * DATA_W) begin : g_bad_cnt
      $error("CNT_W must be twice DATA_W");
   end
   if (DIV_W > DATA_W || DIV_W < 1) begin : g_bad_div
      $error("DIV_W must lie in 1..DATA_W");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W must be at least 6");
   end
   if (DATA_W < NUM_CH) begin : g_bad_data
      $error("DATA_W must hold one bit per channel");
   end

   // ---------------------------------------------------------------
   // address decode
   // ---------------------------------------------------------------
   logic             addr_hi_zero;
   logic             in_map;
   logic [IDX_W-1:0] widx;
   logic             sel_we;

   if (ADDR_W > 6) begin : g_addr_wide
      assign addr_hi_zero = ~|bus_addr_i[ADDR_W-1:6];
   end else begin : g_addr_exact
      assign addr_hi_zero = 1'b1;
   end

   assign in_map = addr_hi_zero && (bus_addr_i[1:0] == 2'b00);
   assign widx   = bus_addr_i[5:2];
   assign sel_we = bus_we_i && in_map;

   logic              wr_lo, wr_hi, cnt_we;
   logic              stat_we, ien_we, wden_we, div_we, snap_take;
   logic [NUM_CH-1:0] cmp_we;

   assign wr_lo     = sel_we && (widx == REG_CNT_LO);
   assign wr_hi     = sel_we && (widx == REG_CNT_HI);
   assign cnt_we    = wr_lo | wr_hi;
   assign stat_we   = sel_we && (widx == REG_STATUS);
   assign ien_we    = sel_we && (widx == REG_IRQ_EN);
   assign wden_we   = sel_we && (widx == REG_WDOG_EN);
   assign div_we    = sel_we && (widx == REG_DIV);
   assign snap_take = sel_we && (widx == REG_SNAP) && bus_wdata_i[0];

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp_dec
      localparam logic [IDX_W-1:0] CIDX = IDX_W'(int'(REG_CMP0) + ch);
      assign cmp_we[ch] = sel_we && (widx == CIDX);
   end

   // ---------------------------------------------------------------
   // control registers
   // ---------------------------------------------------------------
   logic [NUM_CH-1:0] ien_q;
   logic              wden_q;
   logic [DIV_W-1:0]  div_q;
   logic [CNT_W-1:0]  snap_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ien_q  <= '0;
         wden_q <= 1'b0;
         div_q  <= '0;
      end else begin
         if (ien_we)  ien_q  <= bus_wdata_i[NUM_CH-1:0];
         if (wden_we) wden_q <= bus_wdata_i[0];
         if (div_we)  div_q  <= bus_wdata_i[DIV_W-1:0];
      end
   end

   // ---------------------------------------------------------------
   // datapath
   // ---------------------------------------------------------------
   logic                          tick;
   logic [CNT_W-1:0]              cnt_q;
   logic                          step;
   logic [NUM_CH-1:0][DATA_W-1:0] cmp_q;
   logic [NUM_CH-1:0]             status_q;
   logic                          last_hit;

   mt_prescaler #(.DIV_W(DIV_W)) u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .div_i  (div_q),
      .tick_o (tick)
   );

   mt_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick),
      .wr_lo_i (wr_lo),
      .wr_hi_i (wr_hi),
      .wdata_i (bus_wdata_i),
      .cnt_o   (cnt_q),
      .step_o  (step)
   );

   mt_cmp_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cnt_lo_i   (cnt_q[DATA_W-1:0]),
      .step_i     (step),
      .cmp_we_i   (cmp_we),
      .wdata_i    (bus_wdata_i),
      .clr_we_i   (stat_we),
      .clr_mask_i (bus_wdata_i[NUM_CH-1:0]),
      .cmp_o      (cmp_q),
      .status_o   (status_q),
      .last_hit_o (last_hit)
   );

   // coherent 64-bit capture: both halves at one edge
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        snap_q <= '0;
      else if (snap_take) snap_q <= cnt_q;
   end

   // ---------------------------------------------------------------
   // watchdog variant
   // ---------------------------------------------------------------
   if (HAS_WDOG) begin : g_wdog
      logic wdog_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) wdog_q <= 1'b0;
         else         wdog_q <= last_hit & wden_q;
      end
      assign wdog_rst_o = wdog_q;
   end else begin : g_no_wdog
      assign wdog_rst_o = 1'b0;
   end

   assign irq_o = |(status_q & ien_q);

   // ---------------------------------------------------------------
   // read mux
   // ---------------------------------------------------------------
   always_comb begin
      bus_rdata_o = '0;
      if (in_map) begin
         case (widx)
            REG_CNT_LO:  bus_rdata_o = cnt_q[DATA_W-1:0];
            REG_CNT_HI:  bus_rdata_o[HI_W-1:0] = cnt_q[CNT_W-1:DATA_W];
            REG_STATUS:  bus_rdata_o[NUM_CH-1:0] = status_q;
            REG_IRQ_EN:  bus_rdata_o[NUM_CH-1:0] = ien_q;
            REG_WDOG_EN: bus_rdata_o[0] = wden_q;
            REG_DIV:     bus_rdata_o[DIV_W-1:0] = div_q;
            REG_SNAP_LO: bus_rdata_o = snap_q[DATA_W-1:0];
            REG_SNAP_HI: bus_rdata_o[HI_W-1:0] = snap_q[CNT_W-1:DATA_W];
            default: begin
               for (int ch = 0; ch < NUM_CH; ch++) begin
                  if (widx == IDX_W'(int'(REG_CMP0) + ch)) bus_rdata_o = cmp_q[ch];
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/mt_timer_chk.sv
module mt_timer_chk #(
   parameter int unsigned NUM_CH = 6,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 64
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              cnt_we,
   input logic              stat_we,
   input logic              snap_take,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [CNT_W-1:0]  snap_q,
   input logic [NUM_CH-1:0] status_q,
   input logic [DATA_W-1:0] cmp0_q,
   input logic              wden_q,
   input logic              wdog_rst_o
);

   // R2
   snap_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      snap_take |=> (snap_q == $past(cnt_q)));

   // R3
   cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cnt_we |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1))));

   // R4
   match_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_q[0]) |-> ($past(cnt_q[DATA_W-1:0]) == $past(cmp0_q)));

   // R5
   status_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stat_we |=> ((status_q & $past(status_q)) == $past(status_q)));

   // R7
   wdog_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wdog_rst_o |=> !wdog_rst_o);

   // R7
   wdog_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wdog_rst_o |-> $past(wden_q));

endmodule

bind match_timer64 mt_timer_chk #(
   .NUM_CH (NUM_CH),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .cnt_we     (cnt_we),
   .stat_we    (stat_we),
   .snap_take  (snap_take),
   .cnt_q      (cnt_q),
   .snap_q     (snap_q),
   .status_q   (status_q),
   .cmp0_q     (cmp_q[0]),
   .wden_q     (wden_q),
   .wdog_rst_o (wdog_rst_o)
);

// File: tb/match_timer64_tb_top.sv
module match_timer64_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   wire  [31:0] rdata;
   wire         irq;
   wire         wdr;

   always #10 clk = ~clk;

   match_timer64 dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bus_we_i    (we),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irq_o       (irq),
      .wdog_rst_o  (wdr)
   );

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   int roam   = 0;
   bit done   = 1'b0;

   // ---------------- behavioural reference model ----------------
   logic [32:0] m_pre;
   logic [63:0] m_cnt, m_snap;
   logic        m_step, m_wden, m_wdr, m_tick, m_cwr, m_map;
   logic [31:0] m_cmp [6];
   logic [5:0]  m_stat, m_ien, m_hit;
   logic [31:0] m_div;
   logic [3:0]  m_idx;

   task automatic m_reset();
      m_pre = '0; m_cnt = '0; m_snap = '0; m_step = 1'b0; m_wden = 1'b0;
      m_wdr = 1'b0; m_stat = '0; m_ien = '0; m_div = '0;
      for (int n = 0; n < 6; n++) m_cmp[n] = 32'hFFFF_FFFF;
   endtask

   initial m_reset();

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_reset();
      end else begin
         m_map  = (addr[1:0] == 2'b00);
         m_idx  = addr[5:2];
         m_tick = (m_pre >= {m_div, 1'b1});
         for (int n = 0; n < 6; n++) m_hit[n] = m_step && (m_cnt[31:0] == m_cmp[n]);
         m_cwr  = we && m_map && (m_idx <= 4'd1);
         m_wdr  = m_hit[5] && m_wden;
         if (we && m_map && m_idx == 4'd8) m_stat = m_stat & ~wdata[5:0];
         m_stat = m_stat | m_hit;
         if (we && m_map && m_idx == 4'd12 && wdata[0]) m_snap = m_cnt;
         if (m_cwr) begin
            if (m_idx == 4'd0) m_cnt[31:0] = wdata;
            else               m_cnt[63:32] = wdata;
         end else if (m_tick) begin
            m_cnt = m_cnt + 64'd1;
         end
         if (we && m_map && m_idx >= 4'd2 && m_idx <= 4'd7) m_cmp[m_idx - 4'd2] = wdata;
         if (we && m_map && m_idx == 4'd9)  m_ien  = wdata[5:0];
         if (we && m_map && m_idx == 4'd10) m_wden = wdata[0];
         if (we && m_map && m_idx == 4'd11) m_div  = wdata;
         m_step = m_tick && !m_cwr;
         m_pre  = m_tick ? 33'd0 : m_pre + 33'd1;
      end
   end

   function automatic logic [31:0] m_read(logic [5:0] a);
      if (a[1:0] != 2'b00) return 32'd0;
      case (a[5:2])
         4'd0:  return m_cnt[31:0];
         4'd1:  return m_cnt[63:32];
         4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: return m_cmp[a[5:2] - 4'd2];
         4'd8:  return {26'd0, m_stat};
         4'd9:  return {26'd0, m_ien};
         4'd10: return {31'd0, m_wden};
         4'd11: return m_div;
         4'd13: return m_snap[31:0];
         4'd14: return m_snap[63:32];
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(logic [5:0] a);
      if (a[1:0] != 2'b00) return "R8";
      case (a[5:2])
         4'd0, 4'd1, 4'd11: return "R1";
         4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: return "R4";
         4'd8:  return "R5";
         4'd9:  return "R6";
         4'd10: return "R7";
         4'd13, 4'd14: return "R2";
         default: return "R8";
      endcase
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   always @(negedge clk) if (rst_n && wdr) pulses++;

   // one clock: compare outputs against the model, then drive new inputs
   task automatic cyc(logic w, logic [5:0] a, logic [31:0] d);
      @(negedge clk);
      if (rst_n && !done) begin
         check(tag_of(addr), rdata, m_read(addr), "rdata");
         check("R6", {31'd0, irq}, {31'd0, |(m_stat & m_ien)}, "irq");
         check("R7", {31'd0, wdr}, {31'd0, m_wdr}, "wdog_rst");
      end
      we = w; addr = a; wdata = d;
   endtask

   task automatic wr(logic [5:0] a, logic [31:0] d);
      cyc(1'b1, a, d);
   endtask

   task automatic idle(int n);
      repeat (n) begin
         roam = (roam + 1) % 16;
         cyc(1'b0, {roam[3:0], 2'b00}, 32'd0);
      end
   endtask

   task automatic rd_expect(logic [5:0] a, logic [31:0] exp, string req);
      cyc(1'b0, a, 32'd0);
      #1;
      check(req, rdata, exp, "directed read");
   endtask

   // watchdog
   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int p0;
      int r;
      logic [3:0]  ridx;
      logic [5:0]  ra;
      logic [31:0] rd;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: reset values
      rd_expect(6'h00, 32'd0, "R9");
      rd_expect(6'h04, 32'd0, "R9");
      rd_expect(6'h08, 32'hFFFF_FFFF, "R9");
      rd_expect(6'h1C, 32'hFFFF_FFFF, "R9");
      rd_expect(6'h20, 32'd0, "R9");
      rd_expect(6'h24, 32'd0, "R9");
      rd_expect(6'h28, 32'd0, "R9");
      rd_expect(6'h2C, 32'd0, "R9");
      rd_expect(6'h34, 32'd0, "R9");
      rd_expect(6'h38, 32'd0, "R9");

      // freeze the count with a long prescaler period
      wr(6'h2C, 32'h0000_FFFF);
      idle(2);

      // R3: preset both halves
      wr(6'h00, 32'h1234_5678);
      wr(6'h04, 32'h0000_00AB);
      rd_expect(6'h00, 32'h1234_5678, "R3");
      rd_expect(6'h04, 32'h0000_00AB, "R3");

      // R2: capture command with bit 0 clear, then set
      wr(6'h30, 32'hFFFF_FFFE);
      rd_expect(6'h34, 32'd0, "R2");
      wr(6'h30, 32'd1);
      rd_expect(6'h34, 32'h1234_5678, "R2");
      rd_expect(6'h38, 32'h0000_00AB, "R2");

      // R4: a software write onto the compare value sets nothing
      wr(6'h0C, 32'h0000_0500);
      wr(6'h00, 32'h0000_0500);
      idle(4);
      rd_expect(6'h20, 32'd0, "R4");

      // R8: unmapped, capture command and misaligned offsets
      rd_expect(6'h3C, 32'd0, "R8");
      rd_expect(6'h30, 32'd0, "R8");
      rd_expect(6'h09, 32'd0, "R8");
      wr(6'h09, 32'd0);
      rd_expect(6'h08, 32'hFFFF_FFFF, "R8");

      // R4/R6/R7: running count crosses channel 0 and armed channel 5
      wr(6'h00, 32'd100);
      wr(6'h24, 32'd1);
      wr(6'h08, 32'd110);
      wr(6'h1C, 32'd108);
      wr(6'h28, 32'd1);
      p0 = pulses;
      wr(6'h2C, 32'd0);
      idle(40);
      rd_expect(6'h20, 32'h21, "R4");
      check("R6", {31'd0, irq}, 32'd1, "irq asserted");
      check("R7", pulses - p0, 32'd1, "armed pulse count");

      // R5: write-one-to-clear
      wr(6'h20, 32'd0);
      rd_expect(6'h20, 32'h21, "R5");
      wr(6'h20, 32'd1);
      rd_expect(6'h20, 32'h20, "R5");
      check("R6", {31'd0, irq}, 32'd0, "irq released");

      // R7: disarmed watchdog still sets status, no pulse
      wr(6'h28, 32'd0);
      wr(6'h20, 32'h20);
      p0 = pulses;
      wr(6'h00, 32'd100);
      idle(40);
      rd_expect(6'h20, 32'h21, "R7");
      check("R7", pulses - p0, 32'd0, "disarmed pulse count");

      // random traffic, compared against the model every clock
      for (int i = 0; i < 4000; i++) begin
         r    = int'($urandom % 100);
         ridx = 4'($urandom % 16);
         rd   = $urandom;
         ra   = {ridx, 2'b00};
         if ($urandom % 25 == 0) ra[0] = 1'b1;
         if (r < 35) begin
            case (ridx)
               4'd0: rd = (r < 6) ? (32'hFFFF_FFF0 | (rd & 32'hF)) : (m_cnt[31:0] + (rd & 32'h3F));
               4'd1: rd = rd & 32'h3;
               4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7: rd = m_cnt[31:0] + (rd % 32'd40);
               4'd10: rd = rd & 32'h1;
               4'd11: rd = rd % 32'd4;
               default: ;
            endcase
            cyc(1'b1, ra, rd);
         end else begin
            cyc(1'b0, ra, 32'd0);
         end
      end
      idle(4);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule